// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache

This block is a 32 KB data cache with four ways and 16-byte lines. It sits between a 32-bit processor load/store port and a memory port that moves a whole line at a time. An access is held in a request register. Its set index selects one of 512 sets, and its tag is compared against the four lines of that set. A hit is answered from the line store. A miss first picks a victim. If that victim is dirty, the victim is written back, and then the whole line is fetched.

Each access carries three attribute bits. The first makes a write go through to memory at once instead of staying in the line as dirty data. The second makes the access skip the cache completely. The third pins the touched line, so it is never chosen for replacement. If all four lines of a set are pinned, a miss is handled as an uncached access. Replacement uses a three-bit tree per set. Each stored tag carries a parity bit. A tag whose parity does not check is treated as a miss and raises an error flag.

Top module: `dcache4w`

## Requirements
- R1: The byte address splits into offset bits [3:0], set index bits [12:4] and tag bits [31:13]. Every memory-port transaction uses a line-aligned address (bits [3:0] zero).
- R2: A read that hits returns the stored word and causes no memory-port transaction.
- R3: A read miss on a clean or empty victim issues exactly one line read and returns the requested word. The other words of that line then hit. Line reads carry an all-zero byte mask.
- R4: By default a write hit updates only the cached line and marks it dirty. Memory keeps its old contents.
- R5: When the victim is dirty, its full line is written to memory (mask all ones) before the refill read is issued, so the miss takes exactly two transactions in that order.
- R6: With req_wt high, a cached write also issues one memory write. Its mask selects only the enabled bytes of the addressed word (req_be shifted left by 4 x word-in-line), and memory then holds the written data.
- R7: With req_nc high, every read or write is one direct memory transaction and nothing is allocated. A later cached read of the same line still misses.
- R8: With req_lock high, the line the access touches becomes locked. A locked line is never replaced, so it keeps hitting.
- R9: If the indexed set has all four ways locked, a miss is served uncached: one transaction, no allocation, and writes reach memory.
- R10: The victim is the lowest-numbered invalid way. Otherwise it comes from a three-bit tree among the unlocked ways. Bit 0 points to the half (ways 2/3 when set), and bits 1 and 2 point within each half. A hit or fill on a way points both bits away from it. Example: after filling ways 0-3 in order and hitting way 0, the next miss replaces way 2.
- R11: Stored tags carry even parity. err_o pulses only on a tag match whose parity fails, and such a match is a miss. It stays low for clean traffic.
- R12: After reset req_ready is 1 and resp_valid, mem_req and err_o are 0. A request is taken when req_valid and req_ready are both high. Each request yields exactly one single-cycle resp_valid. mem_req holds its address until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_waddr | input | 30 | Word address (byte address bits [31:2]) |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_wt | input | 1 | Write-through attribute |
| req_nc | input | 1 | Cache-disable attribute |
| req_lock | input | 1 | Lock the touched line |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with resp_valid |
| err_o | output | 1 | Tag parity mismatch seen during lookup |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_be | output | 16 | Byte mask for writes |
| mem_wdata | output | 128 | Write line |
| mem_ack | input | 1 | Transaction complete (read data valid) |
| mem_rdata | input | 128 | Read line |

## Verification
The bench targets a dirty victim. A design that refilled before writing back, or that dropped the write-back, would show the wrong order or stale memory. It also targets a miss in a set where every way is locked. A design that ignored locks would evict a pinned line, and the later hits on that line would turn into extra memory traffic. The replacement walk is driven so that the tree alone decides which tag disappears, which catches a flipped pointer bit. Uncached and write-through accesses are checked by counting transactions and inspecting memory. This catches a design that allocates on a bypass or keeps write-through data only in the line.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_WB,
      S_FILL,
      S_MEMR,
      S_MEMW,
      S_DONE
   } dc_state_e;
endpackage

// File: rtl/dc_way.sv
// One way of the cache: tag, parity, status bits and line data per set.
module dc_way #(
   parameter int SETS   = 512,
   parameter int IDX_W  = 9,
   parameter int TAG_W  = 19,
   parameter int LINE_W = 128,
   parameter int WSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  rd_tag,
   output logic              rd_par,
   output logic [LINE_W-1:0] rd_line,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic              rd_lock,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              word_en,
   input  logic [WSEL_W-1:0] word_sel,
   input  logic [3:0]        word_be,
   input  logic [31:0]       word_data,
   input  logic              mark_dirty,
   input  logic              mark_lock
);
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic              par_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];
   logic [SETS-1:0]   valid_q, dirty_q, lock_q;

   assign rd_tag   = tag_q[idx];
   assign rd_par   = par_q[idx];
   assign rd_line  = line_q[idx];
   assign rd_valid = valid_q[idx];
   assign rd_dirty = dirty_q[idx];
   assign rd_lock  = lock_q[idx];

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[idx]  <= fill_tag;
         par_q[idx]  <= ^fill_tag;
         line_q[idx] <= fill_line;
      end else if (word_en) begin
         for (int b = 0; b < 4; b++)
            if (word_be[b])
               line_q[idx][word_sel*32 + b*8 +: 8] <= word_data[b*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         lock_q  <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
         lock_q[idx]  <= 1'b0;
      end else begin
         if (word_en && mark_dirty) dirty_q[idx] <= 1'b1;
         if (mark_lock)             lock_q[idx]  <= 1'b1;
      end
   end
endmodule

// File: rtl/dc_plru.sv
// Three-bit tree replacement state per set, skipping locked ways.
module dc_plru #(
   parameter int SETS  = 512,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       locked,
   input  logic             upd_en,
   input  logic [1:0]       upd_way,
   output logic [1:0]       victim
);
   logic [2:0] tree_q [SETS];
   logic [2:0] cur, nxt;
   logic       left_ok, right_ok, go_right;

   assign cur = tree_q[idx];

   always_comb begin
      left_ok  = !(locked[0] && locked[1]);
      right_ok = !(locked[2] && locked[3]);
      go_right = cur[0] ? right_ok : !left_ok;
      if (go_right)
         victim = {1'b1, locked[2] ? 1'b1 : (locked[3] ? 1'b0 : cur[2])};
      else
         victim = {1'b0, locked[0] ? 1'b1 : (locked[1] ? 1'b0 : cur[1])};
      nxt = cur;
      if (!upd_way[1]) begin
         nxt[0] = 1'b1;
         nxt[1] = !upd_way[0];
      end else begin
         nxt[0] = 1'b0;
         nxt[2] = !upd_way[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (upd_en) begin
         tree_q[idx] <= nxt;
      end
   end
endmodule

// File: rtl/dcache4w.sv
module dcache4w
   import dc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 512,
   parameter int WAYS       = 4,
   parameter bit PAR_EN     = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_we,
   input  logic [ADDR_W-3:0]       req_waddr,
   input  logic [31:0]             req_wdata,
   input  logic [3:0]              req_be,
   input  logic                    req_wt,
   input  logic                    req_nc,
   input  logic                    req_lock,
   output logic                    resp_valid,
   output logic [31:0]             resp_rdata,
   output logic                    err_o,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LINE_BYTES-1:0]   mem_be,
   output logic [LINE_BYTES*8-1:0] mem_wdata,
   input  logic                    mem_ack,
   input  logic [LINE_BYTES*8-1:0] mem_rdata
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int WPL    = LINE_BYTES / 4;
   localparam int WSEL_W = $clog2(WPL);
   localparam int WAY_W  = $clog2(WAYS);

   if (WAYS != 4) begin : g_bad_ways
      $error("replacement tree is built for exactly four ways");
   end
   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 8) begin : g_bad_line
      $error("line size must be a power of two of at least 8 bytes");
   end
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("set count must be a power of two");
   end

   dc_state_e state, nstate;
   logic [ADDR_W-3:0] r_wa;
   logic [31:0]       r_wdata, r_rdata;
   logic [3:0]        r_be;
   logic              r_we, r_wt, r_nc, r_lock;
   logic [WAY_W-1:0]  r_vic;

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic [WSEL_W-1:0] wsel;
   assign idx  = r_wa[OFF_W-2 +: IDX_W];
   assign tag  = r_wa[ADDR_W-3 -: TAG_W];
   assign wsel = r_wa[WSEL_W-1:0];

   logic [TAG_W-1:0]  w_tag  [WAYS];
   logic [LINE_W-1:0] w_line [WAYS];
   logic [WAYS-1:0]   w_par, v_vec, d_vec, l_vec, match_vec, hit_vec, perr_vec;
   logic              fill_en, word_en, lock_en, upd_en;
   logic [WAY_W-1:0]  hit_way, plru_vic, vic_sel;
   logic              hit, all_locked;
   logic [31:0]       hit_word;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      dc_way #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .WSEL_W(WSEL_W)
      ) u_way (
         .clk(clk), .rst_n(rst_n), .idx(idx),
         .rd_tag(w_tag[g]), .rd_par(w_par[g]), .rd_line(w_line[g]),
         .rd_valid(v_vec[g]), .rd_dirty(d_vec[g]), .rd_lock(l_vec[g]),
         .fill_en(fill_en && (r_vic == WAY_W'(g))), .fill_tag(tag), .fill_line(mem_rdata),
         .word_en(word_en && (hit_way == WAY_W'(g))), .word_sel(wsel),
         .word_be(r_be), .word_data(r_wdata), .mark_dirty(!r_wt),
         .mark_lock(lock_en && (hit_way == WAY_W'(g)))
      );
      assign match_vec[g] = v_vec[g] && (w_tag[g] == tag);
      if (PAR_EN) begin : g_par
         assign perr_vec[g] = match_vec[g] && (w_par[g] != ^w_tag[g]);
      end else begin : g_nopar
         assign perr_vec[g] = 1'b0;
      end
      assign hit_vec[g] = match_vec[g] && !perr_vec[g];
   end

   dc_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
      .clk(clk), .rst_n(rst_n), .idx(idx), .locked(l_vec),
      .upd_en(upd_en), .upd_way(hit_way), .victim(plru_vic)
   );

   always_comb begin
      hit        = |hit_vec;
      all_locked = &l_vec;
      hit_way    = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (hit_vec[w]) hit_way = WAY_W'(w);
      vic_sel = plru_vic;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!v_vec[w] || perr_vec[w]) vic_sel = WAY_W'(w);
      hit_word = w_line[hit_way][wsel*32 +: 32];
   end

   always_comb begin
      nstate  = state;
      fill_en = 1'b0;
      word_en = 1'b0;
      lock_en = 1'b0;
      upd_en  = 1'b0;
      unique case (state)
         S_IDLE: if (req_valid) nstate = S_LOOK;
         S_LOOK: begin
            if (r_nc) begin
               nstate = r_we ? S_MEMW : S_MEMR;
            end else if (hit) begin
               upd_en  = 1'b1;
               word_en = r_we;
               lock_en = r_lock;
               nstate  = (r_we && r_wt) ? S_MEMW : S_DONE;
            end else if (all_locked) begin
               nstate = r_we ? S_MEMW : S_MEMR;
            end else if (v_vec[vic_sel] && d_vec[vic_sel] && !perr_vec[vic_sel]) begin
               nstate = S_WB;
            end else begin
               nstate = S_FILL;
            end
         end
         S_WB: if (mem_ack) nstate = S_FILL;
         S_FILL: if (mem_ack) begin
            fill_en = 1'b1;
            nstate  = S_LOOK;
         end
         S_MEMR, S_MEMW: if (mem_ack) nstate = S_DONE;
         S_DONE: nstate = S_IDLE;
         default: nstate = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         r_wa    <= '0;
         r_wdata <= '0;
         r_be    <= '0;
         r_we    <= 1'b0;
         r_wt    <= 1'b0;
         r_nc    <= 1'b0;
         r_lock  <= 1'b0;
         r_vic   <= '0;
         r_rdata <= '0;
      end else begin
         state <= nstate;
         if (state == S_IDLE && req_valid) begin
            r_wa    <= req_waddr;
            r_wdata <= req_wdata;
            r_be    <= req_be;
            r_we    <= req_we;
            r_wt    <= req_wt;
            r_nc    <= req_nc;
            r_lock  <= req_lock;
         end
         if (state == S_LOOK) begin
            r_vic <= vic_sel;
            if (hit && !r_we) r_rdata <= hit_word;
         end
         if (state == S_MEMR && mem_ack) r_rdata <= mem_rdata[wsel*32 +: 32];
      end
   end

   assign req_ready  = (state == S_IDLE);
   assign resp_valid = (state == S_DONE);
   assign resp_rdata = r_rdata;
   assign err_o      = (state == S_LOOK) && !r_nc && (|perr_vec);
   assign mem_req    = (state == S_WB) || (state == S_FILL) || (state == S_MEMR) || (state == S_MEMW);
   assign mem_we     = (state == S_WB) || (state == S_MEMW);
   assign mem_addr   = {((state == S_WB) ? w_tag[r_vic] : tag), idx, {OFF_W{1'b0}}};
   assign mem_be     = (state == S_WB)   ? {LINE_BYTES{1'b1}} :
                       (state == S_MEMW) ? (LINE_BYTES'(r_be) << (wsel * 4)) : '0;
   assign mem_wdata  = (state == S_WB) ? w_line[r_vic] : {WPL{r_wdata}};
endmodule

// File: rtl/dcache4w_chk.sv
module dcache4w_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_ready,
   input logic                  resp_valid,
   input logic                  err_o,
   input logic                  mem_req,
   input logic                  mem_we,
   input logic                  mem_ack,
   input logic [ADDR_W-1:0]     mem_addr,
   input logic [LINE_BYTES-1:0] mem_be
);
   localparam int OFF_W = $clog2(LINE_BYTES);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req && !resp_valid));
   // R12
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);
   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R1
   line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));
   // R6
   write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be != '0));
   // R3
   read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_be == '0));
   // R11
   err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !req_ready);
endmodule

bind dcache4w dcache4w_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
   .err_o(err_o), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/dcache4w_tb.sv
module dcache4w_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic         req_valid, req_ready, req_we, req_wt, req_nc, req_lock;
   logic [29:0]  req_waddr;
   logic [31:0]  req_wdata, resp_rdata;
   logic [3:0]   req_be;
   logic         resp_valid, err_o, mem_req, mem_we, mem_ack;
   logic [31:0]  mem_addr;
   logic [15:0]  mem_be;
   logic [127:0] mem_wdata, mem_rdata;

   dcache4w u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_waddr(req_waddr), .req_wdata(req_wdata), .req_be(req_be),
      .req_wt(req_wt), .req_nc(req_nc), .req_lock(req_lock),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata), .err_o(err_o),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0, fails = 0, mem_ops = 0, err_seen = 0, resp_seen = 0, n_access = 0;
   logic [127:0] mm [logic [27:0]];
   logic [31:0]  sh [logic [29:0]];
   logic [32:0]  oplog [$];

   typedef struct packed {
      logic [31:0] addr;
      logic        we;
      logic [31:0] wdata;
      logic        wt;
      logic        nc;
      logic [3:0]  nmem;
   } vec_t;

   // addr, we, wdata, wt, nc, expected memory transactions
   localparam vec_t TBL [11] = '{
      '{32'h0000_0010, 1'b0, 32'h0,          1'b0, 1'b0, 4'd1},  // R3 miss
      '{32'h0000_0014, 1'b0, 32'h0,          1'b0, 1'b0, 4'd0},  // R2 hit
      '{32'h0000_0018, 1'b1, 32'hDEAD_0018,  1'b0, 1'b0, 4'd0},  // R4 write-back hit
      '{32'h0000_0018, 1'b0, 32'h0,          1'b0, 1'b0, 4'd0},  // R2 hit, new data
      '{32'h0000_0020, 1'b1, 32'hC0DE_0020,  1'b1, 1'b0, 4'd2},  // R6 fill + through
      '{32'h0000_0020, 1'b0, 32'h0,          1'b0, 1'b0, 4'd0},  // R2
      '{32'h0000_0030, 1'b0, 32'h0,          1'b0, 1'b1, 4'd1},  // R7 bypass
      '{32'h0000_0030, 1'b0, 32'h0,          1'b0, 1'b1, 4'd1},  // R7 bypass again
      '{32'h0000_0030, 1'b0, 32'h0,          1'b0, 1'b0, 4'd1},  // R7 not allocated
      '{32'h0000_0044, 1'b1, 32'hBEEF_0044,  1'b0, 1'b1, 4'd1},  // R7 bypass write
      '{32'h0000_0044, 1'b0, 32'h0,          1'b0, 1'b0, 4'd1}   // R7 fill sees it
   };

   function automatic logic [31:0] iw(input logic [31:0] a);
      return {a[31:2], 2'b00} ^ 32'h5A5A_C3C3;
   endfunction

   function automatic logic [127:0] get_line(input logic [27:0] la);
      logic [127:0] l;
      if (mm.exists(la)) return mm[la];
      for (int k = 0; k < 4; k++) l[k*32 +: 32] = iw({la, 4'h0} | 32'(k*4));
      return l;
   endfunction

   function automatic logic [31:0] memword(input logic [31:0] a);
      logic [127:0] l;
      l = get_line(a[31:4]);
      return l[a[3:2]*32 +: 32];
   endfunction

   function automatic logic [31:0] sh_get(input logic [31:0] a);
      if (sh.exists(a[31:2])) return sh[a[31:2]];
      return iw(a);
   endfunction

   function automatic logic [31:0] ta(input int t, input int s, input int w);
      return 32'((t << 13) | (s << 4) | (w << 2));
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // memory model: answers one transaction per request, ack one cycle later
   initial begin
      logic [127:0] ln;
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (rst_n && mem_req) begin
            ln = get_line(mem_addr[31:4]);
            mem_ops++;
            oplog.push_back({mem_we, mem_addr});
            if (mem_we) begin
               for (int b = 0; b < 16; b++)
                  if (mem_be[b]) ln[b*8 +: 8] = mem_wdata[b*8 +: 8];
               mm[mem_addr[31:4]] = ln;
            end else begin
               mem_rdata = ln;
            end
            mem_ack = 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (err_o) err_seen++;
         if (resp_valid) resp_seen++;
      end
   end

   task automatic acc(input string rq, input logic [31:0] a, input logic we,
                      input logic [31:0] wd, input logic wt, input logic nc,
                      input logic lk, input int exp_nm);
      int c0;
      logic [31:0] exp_rd;
      exp_rd = sh_get(a);
      @(negedge clk);
      c0 = mem_ops;
      req_valid = 1'b1; req_waddr = a[31:2]; req_we = we; req_wdata = wd;
      req_be = 4'hF; req_wt = wt; req_nc = nc; req_lock = lk;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid) @(negedge clk);
      n_access++;
      if (!we) chk({rq, " read data"}, resp_rdata, exp_rd);
      else sh[a[31:2]] = wd;
      chk({rq, " memory transactions"}, 32'(mem_ops - c0), 32'(exp_nm));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n0;
      req_valid = 0; req_waddr = '0; req_we = 0; req_wdata = '0; req_be = '0;
      req_wt = 0; req_nc = 0; req_lock = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset ready", 32'(req_ready), 32'd1);
      chk("R12 reset resp", 32'(resp_valid), 32'd0);
      chk("R12 reset mem_req", 32'(mem_req), 32'd0);
      chk("R12 reset err", 32'(err_o), 32'd0);

      foreach (TBL[i])
         acc($sformatf("R2/R3/R4/R6/R7 vector %0d", i), TBL[i].addr, TBL[i].we,
             TBL[i].wdata, TBL[i].wt, TBL[i].nc, 1'b0, int'(TBL[i].nmem));

      // R4: write-back data not in memory; R6: write-through data is
      chk("R4 memory untouched", memword(32'h18), iw(32'h18));
      chk("R6 memory updated", memword(32'h20), 32'hC0DE_0020);

      // R10 replacement walk in set 5, then R5 dirty eviction
      for (int t = 1; t <= 4; t++) acc("R10 fill", ta(t, 5, 0), 0, 0, 0, 0, 0, 1);
      acc("R4 dirty write", ta(1, 5, 1), 1, 32'h1111_2222, 0, 0, 0, 0);
      acc("R10 miss replaces way 2", ta(5, 5, 0), 0, 0, 0, 0, 0, 1);
      acc("R10 tag1 kept", ta(1, 5, 1), 0, 0, 0, 0, 0, 0);
      acc("R10 tag2 kept", ta(2, 5, 0), 0, 0, 0, 0, 0, 0);
      acc("R10 tag4 kept", ta(4, 5, 0), 0, 0, 0, 0, 0, 0);
      chk("R4 dirty not written yet", memword(ta(1, 5, 1)), iw(ta(1, 5, 1)));
      n0 = oplog.size();
      acc("R5 tag3 miss evicts dirty", ta(3, 5, 0), 0, 0, 0, 0, 0, 2);
      chk("R5 first is write", {oplog[n0][32], oplog[n0][31:0]}, {1'b1, ta(1, 5, 0)} );
      chk("R5 second is fill", {oplog[n0+1][32], oplog[n0+1][31:0]}, {1'b0, ta(3, 5, 0)});
      chk("R5 memory holds dirty data", memword(ta(1, 5, 1)), 32'h1111_2222);

      // R8/R9 all four ways locked in set 9
      for (int t = 1; t <= 4; t++) acc("R8 locked fill", ta(t, 9, 0), 0, 0, 0, 0, 1, 1);
      acc("R9 uncached miss", ta(5, 9, 0), 0, 0, 0, 0, 0, 1);
      acc("R9 no allocation", ta(5, 9, 0), 0, 0, 0, 0, 0, 1);
      for (int t = 1; t <= 4; t++) acc("R8 locked line kept", ta(t, 9, 0), 0, 0, 0, 0, 0, 0);
      acc("R9 uncached write", ta(6, 9, 2), 1, 32'h9999_0006, 0, 0, 0, 1);
      chk("R9 write reached memory", memword(ta(6, 9, 2)), 32'h9999_0006);

      // R8/R10 locked way skipped: tree points at way 0 but way 0 is locked
      acc("R8 lock way0", ta(1, 11, 0), 0, 0, 0, 0, 1, 1);
      for (int t = 2; t <= 4; t++) acc("R10 fill", ta(t, 11, 0), 0, 0, 0, 0, 0, 1);
      acc("R8 miss skips locked", ta(5, 11, 0), 0, 0, 0, 0, 0, 1);
      acc("R8 locked tag1 hits", ta(1, 11, 0), 0, 0, 0, 0, 0, 0);
      acc("R10 tag3 hits", ta(3, 11, 0), 0, 0, 0, 0, 0, 0);
      acc("R10 tag4 hits", ta(4, 11, 0), 0, 0, 0, 0, 0, 0);
      acc("R10 tag2 was victim", ta(2, 11, 0), 0, 0, 0, 0, 0, 1);

      repeat (3) @(negedge clk);
      chk("R11 no parity error on clean traffic", 32'(err_seen), 32'd0);
      chk("R12 one response per request", 32'(resp_seen), 32'(n_access));
      begin
         int bad;
         bad = 0;
         foreach (oplog[i]) if (oplog[i][3:0] != 4'h0) bad++;
         chk("R1 line-aligned memory addresses", 32'(bad), 32'd0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule